// File: doc/BRIEF.md
# Channel Start/Current Location Counter Pair

This block keeps the address state of one read/write channel that moves a variable-length record between main memory and a peripheral. A load command writes a start address into two registers. One register keeps that start address for the whole transfer. The other is a location counter that steps by one for every character strobed through the channel.

Each strobed character carries two punctuation bits. A character with both bits set is the record mark, and it ends the transfer. When the transfer ends, the counter points one position past the record mark and the start register still holds the original address. Software can therefore read the record length directly from the difference output. The start register, the difference output and the counter stay valid until the next load. A one-cycle done flag marks the end of the transfer. Peripheral timing is handled outside this block.

Top module: `chan_loc_pair`

## Requirements
- R1: After reset, `start_addr_o`, `cur_addr_o` and `length_o` are zero, and `done_o` is low.
- R2: A cycle with `load_i` high sets both `start_addr_o` and `cur_addr_o` to `load_addr_i` at the next clock edge, arms the channel and clears `done_o`.
- R3: Each `char_strobe_i` accepted by an armed channel raises `cur_addr_o` by exactly one at the next edge. `start_addr_o` changes only on a load.
- R4: An accepted strobe with both `word_mark_i` and `item_mark_i` high is the record mark. At the next edge `cur_addr_o` equals the record-mark address plus one and `done_o` is high. `done_o` is high for that one cycle only.
- R5: An accepted strobe with only one of the two mark bits high, or with neither, advances `cur_addr_o` and does not end the transfer.
- R6: After a record mark and before the next load, strobes are ignored. `cur_addr_o` holds its value and `done_o` stays low.
- R7: `cur_addr_o` wraps modulo 2^ADDR_W, so the all-ones address steps to zero.
- R8: `length_o` always equals (`cur_addr_o` - `start_addr_o`) modulo 2^ADDR_W.
- R9: When `load_i` and `char_strobe_i` are high in the same cycle, the load takes effect and the strobe is dropped.
- R10: Strobes that arrive after reset and before the first load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load start address and arm the channel |
| load_addr_i | input | ADDR_W | Start address of the transfer |
| char_strobe_i | input | 1 | One character moved this cycle |
| word_mark_i | input | 1 | Word punctuation bit of the strobed character |
| item_mark_i | input | 1 | Item punctuation bit of the strobed character |
| start_addr_o | output | ADDR_W | Starting location |
| cur_addr_o | output | ADDR_W | Current location |
| length_o | output | ADDR_W | Current minus starting location |
| done_o | output | 1 | One-cycle pulse after the record mark |

## Verification
A wrong counter step shows up on `cur_addr_o` and `length_o` one cycle after the faulty strobe, and the error stays there until the next load. A wrong armed/idle state appears in one of two ways: a missing or extra `done_o` pulse, or a counter that keeps moving on strobes after the record mark. Either is visible within a cycle of the strobe that exposes it. A start register that is disturbed during the transfer shows on `start_addr_o` and `length_o` at once. The sweep loads every start address of a 6-bit configuration and runs records of several lengths, so that wrap-around lands at every possible distance from the record mark.

// File: rtl/chan_loc_pkg.sv
package chan_loc_pkg;
  localparam int unsigned DEF_ADDR_W = 19;
  typedef enum logic {XFER_IDLE = 1'b0, XFER_RUN = 1'b1} xfer_state_e;
endpackage

// File: rtl/chan_start_reg.sv
module chan_start_reg #(
  parameter int unsigned ADDR_W = chan_loc_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] start_o
);
  logic [ADDR_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_q <= '0;
    else if (load_i) start_q <= addr_i;
  end

  assign start_o = start_q;

  assert_start_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(start_o));
endmodule

// File: rtl/chan_cur_ctr.sv
module chan_cur_ctr #(
  parameter int unsigned ADDR_W = chan_loc_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_o
);
  localparam logic [ADDR_W-1:0] Inc = ADDR_W'(1);

  logic [ADDR_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= '0;
    else if (load_i)  cur_q <= addr_i;
    else if (step_i)  cur_q <= cur_q + Inc;   // wraps modulo 2^ADDR_W
  end

  assign cur_o = cur_q;

  assert_hold_no_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cur_o));
endmodule

// File: rtl/chan_rec_ctl.sv
module chan_rec_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic strobe_i,
  input  logic word_mark_i,
  input  logic item_mark_i,
  output logic step_o,
  output logic done_o
);
  import chan_loc_pkg::*;

  xfer_state_e state_q, state_d;
  logic        done_q;
  logic        rec_mark;

  assign step_o   = strobe_i && (state_q == XFER_RUN) && !load_i;
  assign rec_mark = step_o && word_mark_i && item_mark_i;

  always_comb begin
    state_d = state_q;
    if (load_i)        state_d = XFER_RUN;
    else if (rec_mark) state_d = XFER_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XFER_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= rec_mark;
    end
  end

  assign done_o = done_q;

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(strobe_i && word_mark_i && item_mark_i && !load_i));
  assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o);
endmodule

// File: rtl/chan_loc_pair.sv
module chan_loc_pair #(
  parameter int unsigned ADDR_W = chan_loc_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              char_strobe_i,
  input  logic              word_mark_i,
  input  logic              item_mark_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] length_o,
  output logic              done_o
);
  logic step;

  chan_rec_ctl i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .strobe_i    (char_strobe_i),
    .word_mark_i (word_mark_i),
    .item_mark_i (item_mark_i),
    .step_o      (step),
    .done_o      (done_o)
  );

  chan_start_reg #(.ADDR_W(ADDR_W)) i_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .addr_i  (load_addr_i),
    .start_o (start_addr_o)
  );

  chan_cur_ctr #(.ADDR_W(ADDR_W)) i_cur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .addr_i (load_addr_i),
    .step_i (step),
    .cur_o  (cur_addr_o)
  );

  assign length_o = cur_addr_o - start_addr_o;

  assert_load_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (start_addr_o == $past(load_addr_i)) && (cur_addr_o == $past(load_addr_i)));
  assert_idle_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> $stable(cur_addr_o));
  assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_strobe_i && !load_i && !done_o && $past(load_i)) |=>
      (cur_addr_o == ADDR_W'($past(cur_addr_o) + 1'b1)));
endmodule

// File: tb/test_chan_loc_pair.sv
`timescale 1ns/1ps
module test_chan_loc_pair;
  localparam int unsigned W = 6;
  localparam int unsigned M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld = 1'b0, st = 1'b0, wm = 1'b0, im = 1'b0;
  logic [W-1:0] addr = '0;
  logic [W-1:0] start_o, cur_o, len_o;
  logic         done_o;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  chan_loc_pair #(.ADDR_W(W)) i_chan_loc_pair (
    .clk_i(clk), .rst_ni(rst_n), .load_i(ld), .load_addr_i(addr),
    .char_strobe_i(st), .word_mark_i(wm), .item_mark_i(im),
    .start_addr_o(start_o), .cur_addr_o(cur_o), .length_o(len_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic cyc(input logic l, input int a, input logic s, input logic w, input logic i);
    ld = l; addr = W'(a); st = s; wm = w; im = i;
    @(negedge clk);
    ld = 1'b0; st = 1'b0; wm = 1'b0; im = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 start", start_o, 0); chk("R1 cur", cur_o, 0);
    chk("R1 len", len_o, 0);     chk("R1 done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: strobes before any load
    cyc(0, 0, 1, 1, 1);
    chk("R10 cur", cur_o, 0); chk("R10 done", done_o, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R10 cur", cur_o, 0);

    for (int a = 0; a < M; a++) begin
      for (int n = 1; n <= 8; n++) begin
        cyc(1, a, 0, 0, 0);
        chk("R2 start", start_o, a); chk("R2 cur", cur_o, a);
        chk("R8 len", len_o, 0);     chk("R2 done", done_o, 0);
        for (int k = 1; k < n; k++) begin
          cyc(0, 0, 1, (k % 3) == 1, (k % 3) == 2);   // R5: at most one mark bit
          chk("R5 cur", cur_o, (a + k) % M);
          chk("R5 done", done_o, 0);
          chk("R3 start", start_o, a);
          chk("R8 len", len_o, k);
        end
        cyc(0, 0, 1, 1, 1);
        chk("R4 cur", cur_o, (a + n) % M);
        chk("R4 done", done_o, 1);
        chk("R3 start", start_o, a);
        chk("R8 len", len_o, n);
        if (a + n >= M) chk("R7 wrap", cur_o, a + n - M);
        cyc(0, 0, 0, 0, 0);
        chk("R4 pulse", done_o, 0);
        cyc(0, 0, 1, 1, 1);
        chk("R6 cur", cur_o, (a + n) % M); chk("R6 done", done_o, 0);
        cyc(0, 0, 1, 0, 1);
        chk("R6 cur", cur_o, (a + n) % M);
      end
    end

    // R9: load and strobe together
    cyc(1, 10, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R9 pre", cur_o, 11);
    cyc(1, 40, 1, 1, 1);
    chk("R9 cur", cur_o, 40); chk("R9 start", start_o, 40);
    chk("R9 done", done_o, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R9 armed", cur_o, 41);
    // R7: all-ones steps to zero
    cyc(1, M - 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R7 wrap", cur_o, 0); chk("R8 len", len_o, 1);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule